// File: doc/BRIEF.md
# Transmit FCS insertion controller

This block sits in a byte-wide Ethernet transmit path, ahead of the line interface. Frame bytes arrive with valid, start and end markers. The block forwards each accepted byte one cycle later. For each frame it decides whether a 32-bit frame check sequence is needed. When it is, the block computes a CRC-32 over every byte of the frame and follows the last data byte with four FCS bytes.

Three controls feed the decision, in a fixed priority:

- Auto-pad on transmit forces the FCS.
- Otherwise, a cleared global disable bit enables the FCS.
- Otherwise, a per-frame request flag, sampled with the first byte of the frame, asks for it.

All three are sampled only with the start-of-frame byte. While the FCS bytes go out, the block holds its input ready low so that the frame stream never stalls mid-FCS.

The CRC uses the generator 0x04C11DB7. The register is preset to all ones and inverted before it is sent. Frame data is taken bit 0 first, which matches line order. The FCS is sent starting from its most significant coefficient.

Top module: `fcs_inserter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A byte accepted (`in_valid` and `in_ready` high at a clock edge) appears on `out_data` after that edge, with `out_valid` high and `out_sop` copied from `in_sop`. Bytes keep their order, and no output byte appears without an accepted input or a pending FCS byte.
- R3: With `cfg_autopad` 0 and `cfg_fcs_off` 0, every frame is followed by four FCS bytes.
- R4: With `cfg_autopad` 1, every frame gets the FCS, whatever `cfg_fcs_off` and `in_add_fcs` hold.
- R5: With `cfg_autopad` 0 and `cfg_fcs_off` 1, a frame gets the FCS only if `in_add_fcs` is 1 on its start byte. Without the FCS, `out_eop` rises on the last data byte and nothing follows it.
- R6: The append decision is taken from the control values present with the start-of-frame byte. Changes to `cfg_fcs_off`, `cfg_autopad` or `in_add_fcs` on later bytes of the same frame do not alter it.
- R7: The FCS is the one's complement of a CRC-32 with generator 0x04C11DB7, preset to all ones, over all bytes of the frame. Each input byte is fed bit 0 first. Bit 0 of each output byte is the first on the line, and the 32 FCS bits go out from coefficient 31 down to 0. So the first FCS byte carries coefficient 31 in bit 0 and coefficient 24 in bit 7, and the fourth byte carries coefficient 7 in bit 0.
- R8: When a frame that needs an FCS ends, `in_ready` is low for exactly four cycles, starting the cycle after the end byte is accepted. In those cycles the four FCS bytes are emitted on consecutive cycles, and `out_eop` is high only with the fourth.
- R9: A one-byte frame (`in_sop` and `in_eop` together) is handled like any other, with the decision taken from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fcs_off | input | 1 | Global FCS disable, 0 appends to every frame |
| cfg_autopad | input | 1 | Auto-pad enabled, forces FCS |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is first of frame |
| in_eop | input | 1 | Input byte is last data byte of frame |
| in_data | input | 8 | Input byte |
| in_add_fcs | input | 1 | Per-frame FCS request, read with the start byte |
| in_ready | output | 1 | Block can take a byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is first of frame |
| out_eop | output | 1 | Output byte is last of frame (FCS included) |
| out_data | output | 8 | Output byte |

## Verification
The properties assume a well-formed input stream. Every frame opens with a byte carrying `in_sop` and closes with one carrying `in_eop`, and no start marker appears mid-frame. The bench meets this because its driver builds each frame as a unit: it marks the first and last byte and only offers a byte once `in_ready` is high. The controls may change freely on non-start bytes, so the bench deliberately scrambles them there to exercise the sampling rule.

// File: rtl/fcs_inserter.sv
module fcs_inserter #(
  parameter logic [31:0] POLY = 32'h04C11DB7,
  parameter logic [31:0] SEED = 32'hFFFF_FFFF
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_fcs_off,
  input  logic       cfg_autopad,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [7:0] in_data,
  input  logic       in_add_fcs,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_sop,
  output logic       out_eop,
  output logic [7:0] out_data
);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = {r[30:0], 1'b0} ^ (((r[31] ^ d[i]) == 1'b1) ? POLY : 32'h0);
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  logic [31:0] crc_q, fcs_q;
  logic        frame_fcs_q, busy_q;
  logic [1:0]  cnt_q;

  wire        take     = in_valid && in_ready;
  wire        sop_fcs  = cfg_autopad || !cfg_fcs_off || in_add_fcs;
  wire        use_fcs  = in_sop ? sop_fcs : frame_fcs_q;
  wire [31:0] crc_next = crc_step(in_sop ? SEED : crc_q, in_data);

  assign in_ready = !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q       <= SEED;
      fcs_q       <= '0;
      frame_fcs_q <= 1'b0;
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      out_valid   <= 1'b0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      if (busy_q) begin
        out_valid <= 1'b1;
        out_data  <= rev8(fcs_q[31:24]);
        fcs_q     <= {fcs_q[23:0], 8'h00};
        out_eop   <= (cnt_q == 2'd3);
        cnt_q     <= cnt_q + 2'd1;
        if (cnt_q == 2'd3) busy_q <= 1'b0;
      end else if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_sop   <= in_sop;
        out_eop   <= in_eop && !use_fcs;
        crc_q     <= crc_next;
        if (in_sop) frame_fcs_q <= sop_fcs;
        if (in_eop && use_fcs) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          fcs_q  <= ~crc_next;
        end
      end
    end
  end

endmodule

// File: rtl/fcs_inserter_chk.sv
module fcs_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sop,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_sop,
  input logic       out_eop,
  input logic [7:0] out_data
);

  // R2: accepted byte forwarded one cycle later
  a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data) && out_sop == $past(in_sop));

  // R2: no output without a source
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid);

  // R8: ready low for exactly four cycles
  a_r8_stall_four: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> !in_ready ##1 !in_ready ##1 !in_ready ##1 !in_ready ##1 in_ready);

  // R8: each stalled cycle emits an FCS byte
  a_r8_fcs_emit: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid && !out_sop);

  // R8: frame end leaves the block ready
  a_r8_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop |-> in_ready);

endmodule

bind fcs_inserter fcs_inserter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
  .out_data(out_data)
);

// File: tb/fcs_inserter_bench.sv
module fcs_inserter_bench;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_fcs_off = 1'b0, cfg_autopad = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_add_fcs = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  fcs_inserter u_fcs_inserter (
    .clk(clk), .rst_n(rst_n), .cfg_fcs_off(cfg_fcs_off), .cfg_autopad(cfg_autopad),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .in_add_fcs(in_add_fcs), .in_ready(in_ready), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  typedef struct {
    logic [7:0] data;
    logic       sop;
    logic       eop;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  int low_run = 0;
  bit done = 0;

  function automatic logic [31:0] ref_crc(input logic [7:0] b[], input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic send_frame(input int len, input bit off, input bit ap, input bit add,
                            input bit scramble, input string req);
    logic [7:0] b[];
    logic [31:0] f;
    bit want;
    exp_t e;
    b = new[len];
    for (int i = 0; i < len; i++) b[i] = 8'($urandom);
    want = ap || !off || add;
    f = ref_crc(b, len);
    for (int i = 0; i < len; i++) begin
      e.data = b[i]; e.sop = (i == 0); e.eop = (i == len-1) && !want;
      e.req = (i == len-1 && !want) ? req : "R2";
      exp_q.push_back(e);
    end
    if (want)
      for (int k = 0; k < 4; k++) begin
        e.data = f[8*k +: 8]; e.sop = 0; e.eop = (k == 3); e.req = "R7";
        exp_q.push_back(e);
      end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_data = b[i]; in_sop = (i == 0); in_eop = (i == len-1);
      if (i == 0) begin
        cfg_fcs_off = off; cfg_autopad = ap; in_add_fcs = add;
      end else if (scramble) begin
        cfg_fcs_off = 1'($urandom); cfg_autopad = 1'($urandom); in_add_fcs = 1'($urandom);
      end
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  // monitor: scoreboard compare and stall-length check
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected byte act=%02h exp=none", out_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (out_data !== e.data || out_eop !== e.eop || out_sop !== e.sop) begin
            errors++;
            $display("FAIL %s act=%02h/sop%0b/eop%0b exp=%02h/sop%0b/eop%0b",
                     e.req, out_data, out_sop, out_eop, e.data, e.sop, e.eop);
          end
        end
      end
      if (!in_ready) low_run++;
      else if (low_run != 0) begin
        checks++;
        if (low_run != 4) begin
          errors++;
          $display("FAIL R8 ready-low cycles act=%0d exp=4", low_run);
        end
        low_run = 0;
      end
    end
  end

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin @(posedge clk); wd++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;   // R1 reset state
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 act=valid%0b/ready%0b exp=valid0/ready1", out_valid, in_ready);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;   // R1 after release
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 act=valid%0b/ready%0b exp=valid0/ready1", out_valid, in_ready);
    end

    send_frame(10, 0, 0, 0, 0, "R3");
    send_frame(64, 0, 0, 1, 0, "R3");
    send_frame(12, 0, 1, 0, 0, "R4");
    send_frame(12, 1, 1, 0, 0, "R4");
    send_frame(7,  1, 1, 1, 0, "R4");
    send_frame(9,  1, 0, 0, 0, "R5");
    send_frame(9,  1, 0, 1, 0, "R5");
    send_frame(1,  0, 0, 0, 0, "R9");
    send_frame(1,  1, 0, 0, 0, "R9");
    send_frame(1,  1, 0, 1, 0, "R9");
    for (int r = 0; r < 24; r++)
      send_frame(2 + ($urandom % 70), 1'($urandom), 1'($urandom), 1'($urandom), 1, "R6");
    for (int r = 0; r < 16; r++)
      send_frame(1 + ($urandom % 20), 1, 0, 1'($urandom), 1, "R6");

    repeat (10) @(negedge clk);
    checks++;   // R2 every expected byte delivered
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 pending bytes act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule